// File: doc/BRIEF.md
# Keyed Extended Register Lock

This block is an indexed configuration register file that sits behind an index/data port pair of a display controller. The host first writes an index, then reads or writes the data port. A set of extended configuration registers stays hidden until the host places particular key values in two lock registers. Reads of a hidden register return zero and writes to it are dropped. Software can therefore test for the extensions by writing a pattern into a register that only exists when unlocked and checking whether the pattern reads back.

The first key (index 38h) opens group A: the identification register, the low bank register and a run of general configuration registers. The second key (index 39h) opens group B. The register at index 51h belongs to group B and needs both keys open at once. It carries the two high bits of a 6-bit 64 KB bank number, which is driven on `bank_num`. Reads are registered: the data for a read strobe appears one cycle later, qualified by `rd_valid`.

Top module: `xlock_top`

## Requirements
- R1: After reset both groups are locked, `grp_a_open` and `grp_b_open` are 0, both key registers read 00h, `bank_num` is 0, `rd_valid` is 0 and `rdata` is 00h.
- R2: The key registers at indices 38h and 39h are always writable and always read back the last value written, whether or not either group is open.
- R3: Group A is open exactly while the key at 38h holds 48h. Writing 00h, or any other value, closes it.
- R4: Group B is open exactly while the key at 39h holds A5h. Writing 5Ah, or any other value, closes it. Index 51h can be read or written only while both groups are open.
- R5: Index 30h reads the chip identification byte (parameter `CHIP_ID`, default 90h) while group A is open. Writes never change it.
- R6: Index 35h stores wdata bits 3:0 as the low bank number. It reads back as {4'b0000, stored nibble}, and that nibble drives `bank_num[3:0]`.
- R7: Index 51h stores all 8 bits and reads them back. Its bits 3:2 drive `bank_num[5:4]`.
- R8: While a register's group is locked, a read of it returns 00h and a write to it has no effect. The stored value and `bank_num` are unchanged when the group is reopened.
- R9: Indices `GEN_BASE` to `GEN_BASE+GEN_COUNT-1` (default 40h to 4Fh) are 8-bit group A registers that read back what was written.
- R10: Any other index reads 00h, and writes to it have no effect.
- R11: A read strobe `rd_en` yields `rdata` and a one-cycle `rd_valid` pulse on the next cycle. A read issued in the same cycle as a data write to the same index returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_wr | input | 1 | Load `wdata` into the index register |
| data_wr | input | 1 | Write `wdata` to the register selected by the index |
| rd_en | input | 1 | Read the register selected by the index |
| wdata | input | 8 | Write data for the index or the data port |
| rdata | output | 8 | Registered read data |
| rd_valid | output | 1 | `rdata` holds the result of the previous cycle's read |
| bank_num | output | 6 | Combined 64 KB bank number |
| grp_a_open | output | 1 | Group A unlocked |
| grp_b_open | output | 1 | Group B unlocked |

## Verification
The lock is exercised with the correct unlock keys, with the defined relock keys, and with near-miss keys such as 49h and 12h. These separate an exact-match compare from a loose one, and from a design that latches the open state. Each gated register is written and read in every lock combination: both closed, only A open, both open, and A closed with B open. This shows whether the dual-key register at 51h checks both keys or only one. Writes made while locked are followed by an unlock and a read-back, which catches a design that hides the read but still lets the write through. A read and a write issued in the same cycle tell old-value read timing from write-through.

// File: rtl/xlock_pkg.sv
package xlock_pkg;
  localparam int DW = 8;
  localparam int BANK_LO_W = 4;
  localparam int BANK_HI_W = 2;
  localparam int BANK_W = BANK_LO_W + BANK_HI_W;

  localparam logic [DW-1:0] IDX_ID    = 8'h30;
  localparam logic [DW-1:0] IDX_BANK  = 8'h35;
  localparam logic [DW-1:0] IDX_KEY_A = 8'h38;
  localparam logic [DW-1:0] IDX_KEY_B = 8'h39;
  localparam logic [DW-1:0] IDX_BANKX = 8'h51;

  localparam logic [DW-1:0] KEY_A_OPEN = 8'h48;
  localparam logic [DW-1:0] KEY_B_OPEN = 8'hA5;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ID, SEL_KEY_A, SEL_KEY_B, SEL_BANK, SEL_BANKX, SEL_GEN
  } sel_e;
endpackage

// File: rtl/xlock_decode.sv
module xlock_decode
  import xlock_pkg::*;
#(
  parameter logic [7:0] GEN_BASE = 8'h40,
  parameter int GEN_COUNT = 16,
  localparam int GW = (GEN_COUNT > 1) ? $clog2(GEN_COUNT) : 1
) (
  input  logic [DW-1:0] idx,
  output sel_e          sel,
  output logic [GW-1:0] gen_ofs
);
  logic gen_hit;

  always_comb begin
    gen_hit = ({1'b0, idx} >= {1'b0, GEN_BASE}) &&
              ({1'b0, idx} <  ({1'b0, GEN_BASE} + 9'(GEN_COUNT)));
    gen_ofs = GW'(idx - GEN_BASE);
    if (gen_hit)               sel = SEL_GEN;
    else if (idx == IDX_ID)    sel = SEL_ID;
    else if (idx == IDX_KEY_A) sel = SEL_KEY_A;
    else if (idx == IDX_KEY_B) sel = SEL_KEY_B;
    else if (idx == IDX_BANK)  sel = SEL_BANK;
    else if (idx == IDX_BANKX) sel = SEL_BANKX;
    else                       sel = SEL_NONE;
  end
endmodule

// File: rtl/xlock_keys.sv
module xlock_keys
  import xlock_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_wr,
  input  sel_e          sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] key_a,
  output logic [DW-1:0] key_b,
  output logic          a_open,
  output logic          b_open
);
  logic [DW-1:0] key_a_d, key_a_q, key_b_d, key_b_q;
  logic          en_a, en_b;

  always_comb begin
    en_a    = data_wr && (sel == SEL_KEY_A);
    en_b    = data_wr && (sel == SEL_KEY_B);
    key_a_d = en_a ? wdata : key_a_q;
    key_b_d = en_b ? wdata : key_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_a_q <= '0;
      key_b_q <= '0;
    end else begin
      key_a_q <= key_a_d;
      key_b_q <= key_b_d;
    end
  end

  assign key_a  = key_a_q;
  assign key_b  = key_b_q;
  assign a_open = (key_a_q == KEY_A_OPEN);
  assign b_open = (key_b_q == KEY_B_OPEN);
endmodule

// File: rtl/xlock_store.sv
module xlock_store
  import xlock_pkg::*;
#(
  parameter int GEN_COUNT = 16,
  localparam int GW = (GEN_COUNT > 1) ? $clog2(GEN_COUNT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_ok,
  input  sel_e                 sel,
  input  logic [GW-1:0]        gen_ofs,
  input  logic [DW-1:0]        wdata,
  output logic [BANK_LO_W-1:0] bank_lo,
  output logic [DW-1:0]        bankx,
  output logic [DW-1:0]        gen_rd
);
  logic [BANK_LO_W-1:0] bank_lo_d, bank_lo_q;
  logic [DW-1:0]        bankx_d, bankx_q;
  logic [DW-1:0]        gen_q [GEN_COUNT];

  always_comb begin
    bank_lo_d = bank_lo_q;
    bankx_d   = bankx_q;
    if (wr_ok && (sel == SEL_BANK))  bank_lo_d = wdata[BANK_LO_W-1:0];
    if (wr_ok && (sel == SEL_BANKX)) bankx_d   = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_lo_q <= '0;
      bankx_q   <= '0;
    end else begin
      bank_lo_q <= bank_lo_d;
      bankx_q   <= bankx_d;
    end
  end

  for (genvar g = 0; g < GEN_COUNT; g++) begin : g_gen
    logic we;
    assign we = wr_ok && (sel == SEL_GEN) && (gen_ofs == GW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  gen_q[g] <= '0;
      else if (we) gen_q[g] <= wdata;
    end
  end

  assign bank_lo = bank_lo_q;
  assign bankx   = bankx_q;
  assign gen_rd  = gen_q[gen_ofs];
endmodule

// File: rtl/xlock_top.sv
module xlock_top
  import xlock_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'h90,
  parameter logic [7:0] GEN_BASE = 8'h40,
  parameter int GEN_COUNT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic              data_wr,
  input  logic              rd_en,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rd_valid,
  output logic [BANK_W-1:0] bank_num,
  output logic              grp_a_open,
  output logic              grp_b_open
);
  localparam int GW = (GEN_COUNT > 1) ? $clog2(GEN_COUNT) : 1;

  // reset: asserted asynchronously, released through two flops
  logic rst_s1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  logic [DW-1:0] idx_d, idx_q;
  sel_e          sel;
  logic [GW-1:0] gen_ofs;
  logic [DW-1:0] key_a, key_b, bankx, gen_rd;
  logic [BANK_LO_W-1:0] bank_lo;
  logic          a_open, b_open, grant, wr_ok;
  logic [DW-1:0] rd_val, rdata_d, rdata_q;
  logic          rdv_d, rdv_q;

  xlock_decode #(.GEN_BASE(GEN_BASE), .GEN_COUNT(GEN_COUNT)) u_dec (
    .idx(idx_q), .sel(sel), .gen_ofs(gen_ofs)
  );

  xlock_keys u_keys (
    .clk(clk), .rst_n(rst_sync_n), .data_wr(data_wr), .sel(sel),
    .wdata(wdata), .key_a(key_a), .key_b(key_b),
    .a_open(a_open), .b_open(b_open)
  );

  xlock_store #(.GEN_COUNT(GEN_COUNT)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .wr_ok(wr_ok), .sel(sel),
    .gen_ofs(gen_ofs), .wdata(wdata), .bank_lo(bank_lo),
    .bankx(bankx), .gen_rd(gen_rd)
  );

  // access gate and read selection
  always_comb begin
    unique case (sel)
      SEL_KEY_A, SEL_KEY_B:     grant = 1'b1;
      SEL_ID, SEL_BANK, SEL_GEN: grant = a_open;
      SEL_BANKX:                grant = a_open && b_open;
      default:                  grant = 1'b0;
    endcase
    wr_ok = data_wr && grant;

    unique case (sel)
      SEL_KEY_A: rd_val = key_a;
      SEL_KEY_B: rd_val = key_b;
      SEL_ID:    rd_val = CHIP_ID;
      SEL_BANK:  rd_val = {{(DW-BANK_LO_W){1'b0}}, bank_lo};
      SEL_BANKX: rd_val = bankx;
      SEL_GEN:   rd_val = gen_rd;
      default:   rd_val = '0;
    endcase
    if (!grant) rd_val = '0;
  end

  always_comb begin
    idx_d   = idx_wr ? wdata : idx_q;
    rdata_d = rd_en ? rd_val : rdata_q;
    rdv_d   = rd_en;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      idx_q   <= '0;
      rdata_q <= '0;
      rdv_q   <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      rdata_q <= rdata_d;
      rdv_q   <= rdv_d;
    end
  end

  assign rdata      = rdata_q;
  assign rd_valid   = rdv_q;
  assign bank_num   = {bankx[3:2], bank_lo};
  assign grp_a_open = a_open;
  assign grp_b_open = b_open;
endmodule

// File: rtl/xlock_chk.sv
module xlock_chk
  import xlock_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'h90
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              data_wr,
  input logic              rd_en,
  input logic [DW-1:0]     wdata,
  input logic [DW-1:0]     idx_q,
  input logic [DW-1:0]     rdata,
  input logic              rd_valid,
  input logic [BANK_W-1:0] bank_num,
  input logic              grp_a_open,
  input logic              grp_b_open
);
  AST_KEY_A_MISS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (data_wr && idx_q == IDX_KEY_A && wdata != KEY_A_OPEN) |=> !grp_a_open); // R3
  AST_KEY_B_HIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (data_wr && idx_q == IDX_KEY_B && wdata == KEY_B_OPEN) |=> grp_b_open); // R4
  AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && grp_a_open && idx_q == IDX_ID) |=> (rdata == CHIP_ID)); // R5
  AST_LOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && !grp_a_open && idx_q == IDX_BANK) |=> (rdata == 8'h00)); // R8
  AST_BANK_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !grp_a_open |=> $stable(bank_num[3:0])); // R8
  AST_BANK_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(grp_a_open && grp_b_open) |=> $stable(bank_num[5:4])); // R7
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_en |=> rd_valid); // R11
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_en |=> !rd_valid); // R11
endmodule

bind xlock_top xlock_chk #(.CHIP_ID(CHIP_ID)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .data_wr(data_wr), .rd_en(rd_en),
  .wdata(wdata), .idx_q(idx_q), .rdata(rdata), .rd_valid(rd_valid),
  .bank_num(bank_num), .grp_a_open(grp_a_open), .grp_b_open(grp_b_open)
);

// File: tb/tb_xlock_top.sv
module tb_xlock_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idx_wr = 1'b0, data_wr = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rd_valid;
  logic [5:0] bank_num;
  logic       grp_a_open, grp_b_open;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  xlock_top dut (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .bank_num(bank_num), .grp_a_open(grp_a_open), .grp_b_open(grp_b_open)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] v);
    @(negedge clk); idx_wr = 1'b1; wdata = v;
    @(negedge clk); idx_wr = 1'b0;
  endtask

  task automatic put(input logic [7:0] ix, input logic [7:0] v);
    set_idx(ix);
    @(negedge clk); data_wr = 1'b1; wdata = v;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic get(input logic [7:0] ix, input logic [7:0] exp, input string tag);
    set_idx(ix);
    @(negedge clk); rd_en = 1'b1; exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk); chk({tag, " R11 pulse end"}, rd_valid, 1'b0);
  endtask

  // monitor: pops expectations as read results appear
  initial begin
    forever begin
      @(negedge clk);
      if (rd_valid) begin
        if (exp_q.size() == 0) chk("R11 unexpected rd_valid", 1, 0);
        else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 grp_a_open", grp_a_open, 0);
    chk("R1 grp_b_open", grp_b_open, 0);
    chk("R1 bank_num", bank_num, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 rdata", rdata, 0);
    get(8'h38, 8'h00, "R1 key A reset");
    get(8'h39, 8'h00, "R1 key B reset");
    get(8'h35, 8'h00, "R8 bank locked read");
    put(8'h35, 8'h0F);
    chk("R8 bank_num after locked write", bank_num, 0);
    get(8'h30, 8'h00, "R8 id locked read");

    put(8'h38, 8'h48);
    chk("R3 open on 48h", grp_a_open, 1);
    get(8'h38, 8'h48, "R2 key A readback");
    get(8'h35, 8'h00, "R8 locked write dropped");
    get(8'h30, 8'h90, "R5 id value");
    put(8'h30, 8'h55);
    get(8'h30, 8'h90, "R5 id after write");
    put(8'h35, 8'hFA);
    get(8'h35, 8'h0A, "R6 bank low nibble");
    chk("R6 bank_num low", bank_num, 6'h0A);

    put(8'h51, 8'hFF);
    get(8'h51, 8'h00, "R4 51h needs key B");
    chk("R4 bank_num high untouched", bank_num, 6'h0A);
    put(8'h39, 8'h12);
    chk("R4 near-miss key B", grp_b_open, 0);
    get(8'h39, 8'h12, "R2 key B readback");
    put(8'h39, 8'hA5);
    chk("R4 open on A5h", grp_b_open, 1);
    put(8'h51, 8'hC5);
    get(8'h51, 8'hC5, "R7 51h readback");
    chk("R7 bank_num full", bank_num, 6'h1A);

    put(8'h40, 8'h3C);
    put(8'h4F, 8'hC3);
    get(8'h40, 8'h3C, "R9 first general reg");
    get(8'h4F, 8'hC3, "R9 last general reg");
    put(8'h50, 8'h77);
    get(8'h50, 8'h00, "R10 unmapped 50h");
    get(8'h20, 8'h00, "R10 unmapped 20h");

    // read and write in the same cycle
    set_idx(8'h40);
    @(negedge clk); rd_en = 1'b1; data_wr = 1'b1; wdata = 8'h99;
    exp_q.push_back(8'h3C); tag_q.push_back("R11 read before write");
    @(negedge clk); rd_en = 1'b0; data_wr = 1'b0;
    get(8'h40, 8'h99, "R11 write landed");

    put(8'h38, 8'h00);
    chk("R3 closed on 00h", grp_a_open, 0);
    get(8'h51, 8'h00, "R4 51h with A closed");
    get(8'h35, 8'h00, "R8 bank hidden");
    get(8'h40, 8'h00, "R8 general hidden");
    put(8'h35, 8'h03);
    put(8'h51, 8'h00);
    chk("R8 bank_num kept", bank_num, 6'h1A);
    put(8'h38, 8'h49);
    chk("R3 near-miss key A", grp_a_open, 0);
    get(8'h35, 8'h00, "R3 still hidden");
    put(8'h38, 8'h48);
    get(8'h35, 8'h0A, "R8 bank unchanged after reopen");
    get(8'h40, 8'h99, "R8 general unchanged after reopen");
    put(8'h39, 8'h5A);
    chk("R4 closed on 5Ah", grp_b_open, 0);
    get(8'h51, 8'h00, "R4 51h hidden again");
    put(8'h51, 8'h00);
    put(8'h39, 8'hA5);
    get(8'h51, 8'hC5, "R8 51h unchanged");
    chk("R7 bank_num final", bank_num, 6'h1A);

    repeat (3) @(negedge clk);
    chk("R11 all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule